// File: doc/BRIEF.md
# Programmable Address Select Decoder

The block drives four active-high chip selects for a small 8-bit processor system. Each select owns a mask byte and a compare byte. The mask byte also carries two flag bits: one enables the select, and one picks whether it answers memory cycles or I/O cycles. A select asserts during a valid bus cycle of its type when the chosen address byte, with the mask applied, equals the compare byte. On memory cycles the chosen byte is the upper address byte. On I/O cycles it is the 8-bit port number.

A control register holds a bootstrap flag. Reset sets this flag. While it is set, every memory read goes to select 1, so boot code can run from ROM before any window has been programmed. Software programs the windows through a small register write port and then clears the flag. When more than one window matches a cycle, only the lowest-numbered select asserts. The selects are a combinational function of the current bus cycle and the stored registers.

Top module: `addr_select_decoder`

## Requirements
- R1: After reset the bootstrap flag is set and every mask and compare byte is 00h, so every window is disabled. A memory read then asserts select 1 alone, and an I/O cycle asserts nothing.
- R2: The write offsets are as follows. Offset 0 is the control register. Select k (k = 1..4) has its mask at offset 2k and its compare at offset 2k+1. Writes to offset 1 and to offsets 10 to 15 change nothing.
- R3: A register write changes the selects only from the clock edge that samples the strobe onward. A bus cycle in the same cycle as the write is decoded with the old value.
- R4: Mask bit 0 enables the select. A select whose mask bit 0 is 0 never asserts through its window.
- R5: Mask bit 1 sets the cycle type. With the bit set, the select matches I/O cycles (cyc_io = 1) against cyc_addr[7:0]. With the bit clear, it matches memory cycles (cyc_io = 0) against cyc_addr[15:8].
- R6: Only mask bits 7 to 2 take part in the compare. Bits 1 and 0 of the address byte and of the compare byte never affect a match. For example, mask F1h gives a 4 KB memory window, FDh gives a 1 KB memory window, and FFh gives four consecutive I/O ports.
- R7: While the bootstrap flag is set, a memory read (cyc_valid = 1, cyc_io = 0, cyc_rd = 1) asserts select 1 alone, whatever the windows hold. Memory writes and I/O cycles are decoded through the windows as usual.
- R8: Bit 0 of the control register is the bootstrap flag. Writing 00h clears it, and writing 01h sets it again.
- R9: When several windows match, only the lowest-numbered select asserts. At most one select is high at any time.
- R10: When cyc_valid is low, no select asserts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the release is synchronised inside the block |
| cyc_addr | input | 16 | Bus cycle address |
| cyc_valid | input | 1 | A bus cycle is in progress |
| cyc_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| cyc_rd | input | 1 | 1 = read cycle |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_ofs | input | 4 | Register offset |
| cfg_wr_data | input | 8 | Register write data |
| sel_o | output | 4 | Active-high selects; bit 0 is select 1 |

## Verification
Two functions can fall in the same cycle. A register write can coincide with a bus cycle that the written value would change, and the bootstrap override can coincide with a memory read that a programmed window also claims. The bench provokes the first by placing a compare write and a read of the newly targeted page in one cycle. It expects the old decode in that cycle and the new decode one cycle later. It provokes the second by setting the bootstrap flag again while a lower-priority window covers the read address, and it expects select 1 alone. A behavioural model runs next to the design, and the two are compared on every clock, including during a long random mix of writes and bus cycles.

// File: rtl/addr_sel_pkg.sv
`timescale 1ns/1ps
package addr_sel_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned EN_BIT    = 0;
  localparam int unsigned IO_BIT    = 1;
  localparam int unsigned BOOT_BIT  = 0;
  localparam logic [BYTE_W-1:0] FLAG_BITS = 8'h03;
  localparam int unsigned CTRL_OFS  = 0;

  typedef struct packed {
    logic [BYTE_W-1:0] mask;
    logic [BYTE_W-1:0] cmp;
  } sel_cfg_t;

  function automatic int unsigned mask_ofs(int unsigned k);
    return 2 + 2 * k;
  endfunction

  function automatic int unsigned cmp_ofs(int unsigned k);
    return 3 + 2 * k;
  endfunction
endpackage

// File: rtl/sel_reg_file.sv
`timescale 1ns/1ps
module sel_reg_file
  import addr_sel_pkg::*;
#(
  parameter int unsigned NUM_SEL = 4,
  parameter int unsigned OFS_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFS_W-1:0]  wr_ofs,
  input  logic [BYTE_W-1:0] wr_data,
  output sel_cfg_t          cfg_o [NUM_SEL],
  output logic              boot_mode_o
);
  sel_cfg_t          cfg_q [NUM_SEL];
  sel_cfg_t          cfg_d [NUM_SEL];
  logic [BYTE_W-1:0] ctrl_q, ctrl_d;

  // next-state
  always_comb begin
    ctrl_d = ctrl_q;
    for (int k = 0; k < NUM_SEL; k++) cfg_d[k] = cfg_q[k];
    if (wr_ofs == OFS_W'(CTRL_OFS)) ctrl_d = wr_data;
    for (int k = 0; k < NUM_SEL; k++) begin
      if (wr_ofs == OFS_W'(mask_ofs(k))) cfg_d[k].mask = wr_data;
      if (wr_ofs == OFS_W'(cmp_ofs(k)))  cfg_d[k].cmp  = wr_data;
    end
  end

  // registers, write strobe as clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= BYTE_W'(1) << BOOT_BIT;
      for (int k = 0; k < NUM_SEL; k++) cfg_q[k] <= '0;
    end else if (wr_en) begin
      ctrl_q <= ctrl_d;
      for (int k = 0; k < NUM_SEL; k++) cfg_q[k] <= cfg_d[k];
    end
  end

  always_comb begin
    for (int k = 0; k < NUM_SEL; k++) cfg_o[k] = cfg_q[k];
  end
  assign boot_mode_o = ctrl_q[BOOT_BIT];

  // R8
  boot_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_ofs == OFS_W'(CTRL_OFS) && wr_data == '0) |=> !boot_mode_o);

  for (genvar k = 0; k < NUM_SEL; k++) begin : g_chk
    // R3
    mask_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_ofs == OFS_W'(mask_ofs(k))) |=> (cfg_o[k].mask == $past(wr_data)));
    // R3
    cmp_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_ofs == OFS_W'(cmp_ofs(k))) |=> (cfg_o[k].cmp == $past(wr_data)));
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(cfg_o[k].mask) && $stable(cfg_o[k].cmp)));
  end
endmodule

// File: rtl/sel_window_match.sv
`timescale 1ns/1ps
module sel_window_match
  import addr_sel_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sel_cfg_t          cfg,
  input  logic              cyc_valid,
  input  logic              cyc_io,
  input  logic [ADDR_W-1:0] cyc_addr,
  output logic              hit_o
);
  logic [BYTE_W-1:0] addr_byte;
  logic [BYTE_W-1:0] cmp_mask;
  logic              type_ok;
  logic              bits_ok;

  always_comb begin
    addr_byte = cyc_io ? cyc_addr[BYTE_W-1:0] : cyc_addr[ADDR_W-1 -: BYTE_W];
    cmp_mask  = cfg.mask & ~FLAG_BITS;
    type_ok   = (cfg.mask[IO_BIT] == cyc_io);
    bits_ok   = (((addr_byte ^ cfg.cmp) & cmp_mask) == '0);
    hit_o     = cyc_valid && cfg.mask[EN_BIT] && type_ok && bits_ok;
  end

  // R4
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.mask[EN_BIT] |-> !hit_o);
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_valid |-> !hit_o);
endmodule

// File: rtl/sel_priority.sv
`timescale 1ns/1ps
module sel_priority #(
  parameter int unsigned NUM_SEL = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SEL-1:0] hit,
  input  logic               boot_force,
  output logic [NUM_SEL-1:0] sel_o
);
  logic [NUM_SEL-1:0] lowest;

  always_comb begin
    lowest = hit & (~hit + NUM_SEL'(1));
    sel_o  = boot_force ? NUM_SEL'(1) : lowest;
  end

  // R9
  single_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_o));
  // R9
  sel_from_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_force |-> ((sel_o & ~hit) == '0));
endmodule

// File: rtl/addr_select_decoder.sv
`timescale 1ns/1ps
module addr_select_decoder
  import addr_sel_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned NUM_SEL = 4,
  parameter int unsigned OFS_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  cyc_addr,
  input  logic               cyc_valid,
  input  logic               cyc_io,
  input  logic               cyc_rd,
  input  logic               cfg_wr_en,
  input  logic [OFS_W-1:0]   cfg_wr_ofs,
  input  logic [BYTE_W-1:0]  cfg_wr_data,
  output logic [NUM_SEL-1:0] sel_o
);
  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_n_int;
  sel_cfg_t               cfg [NUM_SEL];
  logic                   boot_mode;
  logic [NUM_SEL-1:0]     hit;
  logic                   boot_force;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[SYNC_STAGES-1];

  sel_reg_file #(.NUM_SEL(NUM_SEL), .OFS_W(OFS_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .wr_en      (cfg_wr_en),
    .wr_ofs     (cfg_wr_ofs),
    .wr_data    (cfg_wr_data),
    .cfg_o      (cfg),
    .boot_mode_o(boot_mode)
  );

  for (genvar k = 0; k < NUM_SEL; k++) begin : g_win
    sel_window_match #(.ADDR_W(ADDR_W)) u_match (
      .clk      (clk),
      .rst_n    (rst_n_int),
      .cfg      (cfg[k]),
      .cyc_valid(cyc_valid),
      .cyc_io   (cyc_io),
      .cyc_addr (cyc_addr),
      .hit_o    (hit[k])
    );
  end

  assign boot_force = boot_mode && cyc_valid && cyc_rd && !cyc_io;

  sel_priority #(.NUM_SEL(NUM_SEL)) u_prio (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .hit       (hit),
    .boot_force(boot_force),
    .sel_o     (sel_o)
  );

  // R10
  no_cycle_no_sel_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    !cyc_valid |-> (sel_o == '0));
  // R7
  boot_read_rom_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (boot_mode && cyc_valid && cyc_rd && !cyc_io) |-> (sel_o == NUM_SEL'(1)));
endmodule

// File: tb/addr_select_decoder_bench.sv
`timescale 1ns/1ps
module addr_select_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cyc_addr;
  logic        cyc_valid, cyc_io, cyc_rd;
  logic        cfg_wr_en;
  logic [3:0]  cfg_wr_ofs;
  logic [7:0]  cfg_wr_data;
  logic [3:0]  sel_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  int m_mask [4];
  int m_cmp  [4];
  bit m_boot;

  always #10 clk = ~clk;

  addr_select_decoder u_addr_select_decoder (
    .clk(clk), .rst_n(rst_n), .cyc_addr(cyc_addr), .cyc_valid(cyc_valid),
    .cyc_io(cyc_io), .cyc_rd(cyc_rd), .cfg_wr_en(cfg_wr_en),
    .cfg_wr_ofs(cfg_wr_ofs), .cfg_wr_data(cfg_wr_data), .sel_o(sel_o)
  );

  // behavioural model state
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_boot = 1'b1;
      for (int k = 0; k < 4; k++) begin m_mask[k] = 0; m_cmp[k] = 0; end
    end else if (cfg_wr_en) begin
      if (cfg_wr_ofs == 0) m_boot = cfg_wr_data[0];
      else if (cfg_wr_ofs >= 2 && cfg_wr_ofs <= 9) begin
        if (cfg_wr_ofs % 2 == 0) m_mask[cfg_wr_ofs/2 - 1] = int'(cfg_wr_data);
        else                     m_cmp[cfg_wr_ofs/2 - 1]  = int'(cfg_wr_data);
      end
    end
  end

  function automatic logic [3:0] ref_sel();
    int b;
    if (!cyc_valid) return 4'b0000;
    if (m_boot && !cyc_io && cyc_rd) return 4'b0001;
    b = cyc_io ? int'(cyc_addr) % 256 : int'(cyc_addr) / 256;
    for (int k = 0; k < 4; k++) begin
      if ((m_mask[k] % 2 == 1) && (((m_mask[k] / 2) % 2 == 1) == cyc_io) &&
          ((b & m_mask[k] & 252) == (m_cmp[k] & m_mask[k] & 252)))
        return 4'(1 << k);
    end
    return 4'b0000;
  endfunction

  task automatic judge(input logic [3:0] exp, input string req);
    checks++;
    if (sel_o !== exp) begin
      errors++;
      $display("FAIL %s: sel_o=%b expected=%b addr=%h io=%b rd=%b", req, sel_o, exp,
               cyc_addr, cyc_io, cyc_rd);
    end
  endtask

  // one clock: drive at falling edge, sample mid low phase
  task automatic step(input logic [15:0] a, input logic io, input logic rd, input logic v,
                      input logic we, input logic [3:0] ofs, input logic [7:0] d,
                      input string req);
    @(negedge clk);
    cyc_addr = a; cyc_io = io; cyc_rd = rd; cyc_valid = v;
    cfg_wr_en = we; cfg_wr_ofs = ofs; cfg_wr_data = d;
    #5;
    judge(ref_sel(), {req, " model"});
  endtask

  task automatic bus(input logic [15:0] a, input logic io, input logic rd,
                     input logic [3:0] exp, input string req);
    step(a, io, rd, 1'b1, 1'b0, 4'd0, 8'h00, req);
    judge(exp, req);
  endtask

  task automatic wreg(input logic [3:0] ofs, input logic [7:0] d, input string req);
    step(16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, ofs, d, req);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cyc_addr = 0; cyc_valid = 0; cyc_io = 0; cyc_rd = 0;
    cfg_wr_en = 0; cfg_wr_ofs = 0; cfg_wr_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state, R7 boot read
    bus(16'h1234, 1'b0, 1'b1, 4'b0001, "R1");
    bus(16'h0020, 1'b1, 1'b1, 4'b0000, "R1");
    bus(16'h1234, 1'b0, 1'b0, 4'b0000, "R7");
    // R8 leave bootstrap
    wreg(4'd0, 8'h00, "R8");
    bus(16'h1234, 1'b0, 1'b1, 4'b0000, "R8");
    // R5 memory window of 4 KB for select 1
    wreg(4'd2, 8'hF1, "R2");
    wreg(4'd3, 8'h00, "R2");
    bus(16'h0ABC, 1'b0, 1'b1, 4'b0001, "R5");
    bus(16'h0FFF, 1'b0, 1'b0, 4'b0001, "R5");
    bus(16'h1000, 1'b0, 1'b1, 4'b0000, "R5");
    // R3 write and bus cycle together
    step(16'h1000, 1'b0, 1'b1, 1'b1, 1'b1, 4'd3, 8'h10, "R3");
    judge(4'b0000, "R3");
    bus(16'h1000, 1'b0, 1'b1, 4'b0001, "R3");
    wreg(4'd3, 8'h00, "R3");
    // R4 enable bit
    wreg(4'd2, 8'hF0, "R4");
    bus(16'h0ABC, 1'b0, 1'b1, 4'b0000, "R4");
    wreg(4'd2, 8'hF1, "R4");
    bus(16'h0ABC, 1'b0, 1'b1, 4'b0001, "R4");
    // R5 I/O window on select 4
    wreg(4'd8, 8'hFF, "R5");
    wreg(4'd9, 8'h20, "R5");
    bus(16'h0022, 1'b1, 1'b0, 4'b1000, "R5");
    bus(16'h0024, 1'b1, 1'b0, 4'b0000, "R5");
    bus(16'h2000, 1'b0, 1'b1, 4'b0000, "R5");
    // R6 low compare bits ignored
    wreg(4'd9, 8'h23, "R6");
    bus(16'h0020, 1'b1, 1'b1, 4'b1000, "R6");
    bus(16'h0023, 1'b1, 1'b1, 4'b1000, "R6");
    // R9 overlap
    wreg(4'd4, 8'hFD, "R9");
    wreg(4'd5, 8'h00, "R9");
    bus(16'h0100, 1'b0, 1'b1, 4'b0001, "R9");
    wreg(4'd2, 8'hF0, "R9");
    bus(16'h0100, 1'b0, 1'b1, 4'b0010, "R9");
    bus(16'h0400, 1'b0, 1'b1, 4'b0000, "R6");
    // R2 unused offsets
    wreg(4'd1, 8'hFF, "R2");
    wreg(4'd10, 8'hFF, "R2");
    wreg(4'd15, 8'hFF, "R2");
    bus(16'h0020, 1'b1, 1'b1, 4'b1000, "R2");
    bus(16'h0100, 1'b0, 1'b1, 4'b0010, "R2");
    bus(16'h8000, 1'b0, 1'b1, 4'b0000, "R2");
    // R7 bootstrap re-entered over a window
    wreg(4'd0, 8'h01, "R8");
    bus(16'h0100, 1'b0, 1'b1, 4'b0001, "R7");
    bus(16'h0020, 1'b1, 1'b1, 4'b1000, "R7");
    bus(16'h0100, 1'b0, 1'b0, 4'b0010, "R7");
    // R10 idle bus
    step(16'h0100, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 8'h00, "R10");
    judge(4'b0000, "R10");

    // random mix against the model
    for (int i = 0; i < 4000; i++) begin
      logic we;
      we = ($urandom % 4) == 0;
      step(16'($urandom), 1'($urandom), 1'($urandom), ($urandom % 8) != 0, we,
           4'($urandom), 8'($urandom), "R9");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule